// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside a small CPU core and decides when the core should leave its current program for a handler. Five sources can request service: two active-low external pins, two timer overflow flags and a serial flag made from a transmit-done and a receive-done level. A software-owned enable byte gates every source one by one and also as a group. A priority byte promotes any source to the upper of two levels. The core reports each instruction boundary and each return from a handler. At a boundary the block may issue a one-cycle take pulse, together with the handler's entry address and a clear pulse for the flag being served.

The block keeps a record of which levels are in service, so a handler can be nested inside another. The record is a four-state machine. `LV_IDLE` means no handler is running. `LV_LO` means a lower-level handler runs. `LV_HI` means an upper-level handler runs with nothing beneath it. `LV_LO_HI` means an upper-level handler has pre-empted a lower one. The transitions are:
- take-low: `LV_IDLE`→`LV_LO`.
- take-high: `LV_IDLE`→`LV_HI` and `LV_LO`→`LV_LO_HI`.
- return: `LV_LO`→`LV_IDLE`, `LV_HI`→`LV_IDLE` and `LV_LO_HI`→`LV_LO`.
- hold: any state stays where it is when nothing happens.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `take_irq` is 0, `vec_addr` is 0x0000, `flag_clr` is 0, and no level is in service.
- R2: The entry address is 0x0003 + 8·k, where k is the source index: 0 is external pin 0, 1 is timer 0, 2 is external pin 1, 3 is timer 1 and 4 is serial. This gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. `vec_addr` keeps the last taken address.
- R3: Among pending requests on the same level, the lowest index wins.
- R4: A pending source whose bit k in `irq_prio` is 1 beats every pending source whose bit is 0, whatever their indices.
- R5: A source can be taken only when `irq_en[7]` is 1 and its own bit `irq_en[k]` (k = 0..4) is 1.
- R6: A take happens only at a clock edge where `insn_done` is 1. `take_irq`, `vec_addr` and `flag_clr` change at that same edge and are visible in the following cycle. `take_irq` is high for one cycle per take.
- R7: An external request is latched when its pin falls. The pin goes through a two-stage synchronizer, and the request becomes pending three edges after the pin goes low. A pin held low yields only one request.
- R8: On a take, `flag_clr` carries a one-hot pulse at bit k for sources 0..3, and the latched external request is dropped. For the serial source, `flag_clr` stays 0 and the request stays pending.
- R9: An upper-level request pre-empts a running lower-level handler. No request pre-empts a handler at the same or a higher level.
- R10: `handler_ret` closes the innermost open level: `LV_LO_HI` returns to `LV_LO`, and the other states return to `LV_IDLE`. No take happens at an edge where `handler_ret` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_n | input | 1 | External request pin 0, falling edge |
| ext1_n | input | 1 | External request pin 1, falling edge |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_tx_flag | input | 1 | Serial transmit-done flag |
| ser_rx_flag | input | 1 | Serial receive-done flag |
| irq_en | input | 8 | Bit 7 global enable, bits 0..4 per-source enables |
| irq_prio | input | 8 | Bits 0..4: 1 = upper level |
| insn_done | input | 1 | Instruction boundary strobe |
| handler_ret | input | 1 | Return-from-handler strobe |
| take_irq | output | 1 | One-cycle take pulse |
| vec_addr | output | 16 | Handler entry address |
| flag_clr | output | 5 | One-hot flag clear, bit k per source |

## Verification
`take_irq`, `vec_addr` and `flag_clr` are registered. They are due one edge after the edge that sees `insn_done`, and a falling external pin adds three edges before the request can compete. The bench drives inputs on the falling clock edge. A behavioural model advances on each rising edge and is compared with the outputs on the next falling edge, so every cycle's result is checked exactly in the cycle it is due. Directed scenarios then count the takes and check their addresses against fixed constants.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC     = 5;
    localparam int IDXW     = $clog2(NSRC);
    localparam int ADDR_W   = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int EA_BIT   = 7;
    localparam int SER_IDX  = 4;

    typedef enum logic [1:0] {
        LV_IDLE,
        LV_LO,
        LV_HI,
        LV_LO_HI
    } lvl_e;

    typedef struct packed {
        logic            found;
        logic            hi;
        logic [IDXW-1:0] idx;
        logic [NSRC-1:0] onehot;
    } win_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic clr,
    output logic flag
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             fall;

    always_comb begin
        fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            flag    <= 1'b0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pin_n};
            flag    <= (flag & ~clr) | fall;
        end
    end

    p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> flag);
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] prio,
    output win_t            win
);
    logic [NSRC-1:0] req_hi;
    logic [NSRC-1:0] req_lo;
    logic [NSRC-1:0] sel;

    always_comb begin
        req_hi     = pend & prio;
        req_lo     = pend & ~prio;
        sel        = (|req_hi) ? req_hi : req_lo;
        win.found  = |sel;
        win.hi     = |req_hi;
        win.onehot = sel & (~sel + {{(NSRC-1){1'b0}}, 1'b1});
        win.idx    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (sel[i]) begin
                win.idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic busy_any,
    output logic busy_hi
);
    lvl_e state_q;
    lvl_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_IDLE: begin
                if (take) state_d = take_hi ? LV_HI : LV_LO;
            end
            LV_LO: begin
                if (ret) state_d = LV_IDLE;
                else if (take && take_hi) state_d = LV_LO_HI;
            end
            LV_HI: begin
                if (ret) state_d = LV_IDLE;
            end
            LV_LO_HI: begin
                if (ret) state_d = LV_LO;
            end
            default: state_d = LV_IDLE;
        endcase
    end

    always_comb begin
        busy_any = (state_q != LV_IDLE);
        busy_hi  = (state_q == LV_HI) || (state_q == LV_LO_HI);
    end

    p_lo_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_hi) |-> (state_q == LV_IDLE));
    p_hi_not_nested_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_hi) |-> !(state_q == LV_HI || state_q == LV_LO_HI));
    p_unnest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_LO_HI && ret) |=> (state_q == LV_LO));
    p_no_take_on_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret |-> !take);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [NSRC-1:0] AUTO_CLR    = 5'b01111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext0_n,
    input  logic              ext1_n,
    input  logic              tmr0_flag,
    input  logic              tmr1_flag,
    input  logic              ser_tx_flag,
    input  logic              ser_rx_flag,
    input  logic [7:0]        irq_en,
    input  logic [7:0]        irq_prio,
    input  logic              insn_done,
    input  logic              handler_ret,
    output logic              take_irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NSRC-1:0]   flag_clr
);
    localparam int NEXT = 2;
    localparam int EXT_IDX [NEXT] = '{0, 2};

    logic [NEXT-1:0] ext_pins;
    logic [NEXT-1:0] ext_flags;
    logic [NEXT-1:0] ext_clr;
    logic [NSRC-1:0] raw_req;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] clr_now;
    win_t            win;
    logic            busy_any;
    logic            busy_hi;
    logic            level_ok;
    logic            take_now;
    logic [ADDR_W-1:0] vec_now;

    assign ext_pins = {ext1_n, ext0_n};

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        irq_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_n(ext_pins[g]),
            .clr  (ext_clr[g]),
            .flag (ext_flags[g])
        );
        assign ext_clr[g] = clr_now[EXT_IDX[g]];
    end

    always_comb begin
        raw_req = {ser_tx_flag | ser_rx_flag, tmr1_flag, ext_flags[1], tmr0_flag, ext_flags[0]};
        pend    = raw_req & irq_en[NSRC-1:0] & {NSRC{irq_en[EA_BIT]}};
    end

    irq_arbiter u_arb (
        .pend(pend),
        .prio(irq_prio[NSRC-1:0]),
        .win (win)
    );

    always_comb begin
        level_ok = win.hi ? !busy_hi : !busy_any;
        take_now = win.found && level_ok && insn_done && !handler_ret;
        clr_now  = take_now ? (win.onehot & AUTO_CLR) : '0;
        vec_now  = ADDR_W'(VEC_BASE) + ADDR_W'(win.idx) * ADDR_W'(VEC_STEP);
    end

    irq_level_fsm u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take_now),
        .take_hi (win.hi),
        .ret     (handler_ret),
        .busy_any(busy_any),
        .busy_hi (busy_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_irq <= 1'b0;
            vec_addr <= '0;
            flag_clr <= '0;
        end else begin
            take_irq <= take_now;
            flag_clr <= clr_now;
            if (take_now) vec_addr <= vec_now;
        end
    end

    p_take_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(insn_done));
    p_no_take_after_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(handler_ret));
    p_global_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(irq_en[EA_BIT]));
    p_vec_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr[2:0] == 3'd3 && vec_addr <= ADDR_W'(VEC_BASE + VEC_STEP * (NSRC - 1))));
    p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr) && !flag_clr[SER_IDX]);
    p_clr_with_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> take_irq);
    p_vec_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> $stable(vec_addr));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext0_n = 1'b1, ext1_n = 1'b1;
    logic        tmr0 = 1'b0, tmr1 = 1'b0, ser_tx = 1'b0, ser_rx = 1'b0;
    logic [7:0]  irq_en = 8'h00, irq_prio = 8'h00;
    logic        insn_done = 1'b0, handler_ret = 1'b0;
    logic        take_irq;
    logic [15:0] vec_addr;
    logic [4:0]  flag_clr;

    int total = 0, bad = 0;
    int got_n = 0;
    int got_vec [16];
    int got_clr [16];

    // reference model state
    bit [1:0] m_s0, m_s1, m_pv, m_ef;
    int       m_lvl;
    bit       e_take;
    int       e_vec, e_clr;

    always #4 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
        .tmr0_flag(tmr0), .tmr1_flag(tmr1), .ser_tx_flag(ser_tx), .ser_rx_flag(ser_rx),
        .irq_en(irq_en), .irq_prio(irq_prio), .insn_done(insn_done),
        .handler_ret(handler_ret), .take_irq(take_irq), .vec_addr(vec_addr),
        .flag_clr(flag_clr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = 2'b11; m_s1 = 2'b11; m_pv = 2'b11; m_ef = 2'b00;
            m_lvl = 0; e_take = 0; e_vec = 0; e_clr = 0;
        end else begin
            bit [4:0] req;
            bit [1:0] fall;
            bit found, hi, ok;
            int w;
            req = {ser_tx | ser_rx, tmr1, m_ef[1], tmr0, m_ef[0]};
            found = 0; hi = 0; w = 0;
            for (int pass = 1; pass >= 0; pass--)
                for (int i = 0; i < 5; i++)
                    if (!found && req[i] && irq_en[i] && irq_en[7] && (irq_prio[i] == pass)) begin
                        found = 1; w = i; hi = (pass == 1);
                    end
            ok = found && insn_done && !handler_ret && (hi ? (m_lvl < 2) : (m_lvl == 0));
            e_take = ok;
            e_clr = (ok && w != 4) ? (1 << w) : 0;
            if (ok) e_vec = 3 + 8 * w;
            fall = m_pv & ~m_s1;
            m_ef[0] = (m_ef[0] && !(ok && w == 0)) || fall[0];
            m_ef[1] = (m_ef[1] && !(ok && w == 2)) || fall[1];
            m_pv = m_s1; m_s1 = m_s0; m_s0 = {ext1_n, ext0_n};
            if (handler_ret) m_lvl = (m_lvl == 3) ? 1 : 0;
            else if (ok) m_lvl = hi ? ((m_lvl == 1) ? 3 : 2) : 1;
        end
    end

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(take_irq == e_take, "R6 take_irq", int'(take_irq), int'(e_take));
        chk(int'(vec_addr) == e_vec, "R2 vec_addr", int'(vec_addr), e_vec);
        chk(int'(flag_clr) == e_clr, "R8 flag_clr", int'(flag_clr), e_clr);
        if (take_irq && got_n < 16) begin
            got_vec[got_n] = int'(vec_addr);
            got_clr[got_n] = int'(flag_clr);
            got_n++;
        end
        if (flag_clr[1]) tmr0 = 1'b0;
        if (flag_clr[3]) tmr1 = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_ret();
        insn_done = 1'b0; handler_ret = 1'b1; step();
        handler_ret = 1'b0; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(take_irq == 1'b0 && vec_addr == 16'h0 && flag_clr == 5'h0, "R1 reset outputs",
            int'(vec_addr), 0);

        // R7 / R2: single falling edge on pin 0, held low
        irq_en = 8'h81; insn_done = 1'b1; ext0_n = 1'b0; steps(6);
        ext0_n = 1'b1; steps(2);
        chk(got_n == 1, "R7 one take per edge", got_n, 1);
        chk(got_vec[0] == 'h03, "R2 ext0 vector", got_vec[0], 'h03);
        chk(got_clr[0] == 'h01, "R8 ext0 clear", got_clr[0], 'h01);
        do_ret(); insn_done = 1'b1; steps(4);
        chk(got_n == 1, "R8 ext0 dropped after take", got_n, 1);

        // R6 no take without boundary, then R3 default order
        got_n = 0; insn_done = 1'b0; irq_en = 8'h8A; tmr0 = 1'b1; tmr1 = 1'b1; steps(4);
        chk(got_n == 0, "R6 no boundary no take", got_n, 0);
        insn_done = 1'b1; step(); insn_done = 1'b0; steps(2);
        chk(got_n == 1 && got_vec[0] == 'h0B, "R3 timer0 before timer1", got_vec[0], 'h0B);
        do_ret(); insn_done = 1'b1; steps(3);
        chk(got_n == 2 && got_vec[1] == 'h1B, "R3 timer1 second", got_vec[1], 'h1B);
        do_ret();

        // R4 priority override, R9 no pre-emption from lower level
        got_n = 0; irq_prio = 8'h08; tmr0 = 1'b1; tmr1 = 1'b1; insn_done = 1'b1; steps(5);
        chk(got_n == 1 && got_vec[0] == 'h1B, "R4 high timer1 first", got_vec[0], 'h1B);
        do_ret(); insn_done = 1'b1; steps(3);
        chk(got_n == 2 && got_vec[1] == 'h0B, "R4 low timer0 after return", got_vec[1], 'h0B);
        do_ret();

        // R9 pre-emption of a low handler, then nesting unwound by R10
        got_n = 0; irq_prio = 8'h08; irq_en = 8'h8E; tmr0 = 1'b1; insn_done = 1'b1; steps(3);
        tmr1 = 1'b1; steps(3);
        chk(got_n == 2 && got_vec[1] == 'h1B, "R9 high pre-empts low", got_vec[1], 'h1B);
        ext1_n = 1'b0; steps(3); ext1_n = 1'b1; steps(5);
        chk(got_n == 2, "R9 low blocked under nest", got_n, 2);
        do_ret(); insn_done = 1'b1; steps(4);
        chk(got_n == 2, "R10 one return leaves low open", got_n, 2);
        do_ret(); insn_done = 1'b1; steps(4);
        chk(got_n == 3 && got_vec[2] == 'h13, "R10 ext1 after full unwind", got_vec[2], 'h13);
        do_ret(); irq_prio = 8'h00;

        // R5 global and per-source enables
        got_n = 0; irq_en = 8'h0A; tmr0 = 1'b1; insn_done = 1'b1; steps(5);
        chk(got_n == 0, "R5 global enable off", got_n, 0);
        irq_en = 8'h88; steps(5);
        chk(got_n == 0, "R5 source bit off", got_n, 0);
        irq_en = 8'h8A; steps(3);
        chk(got_n == 1 && got_vec[0] == 'h0B, "R5 enabled take", got_vec[0], 'h0B);
        do_ret();

        // R8 serial not cleared
        got_n = 0; irq_en = 8'h90; ser_rx = 1'b1; insn_done = 1'b1; steps(3);
        chk(got_n == 1 && got_vec[0] == 'h23, "R2 serial vector", got_vec[0], 'h23);
        chk(got_clr[0] == 0, "R8 serial no clear", got_clr[0], 0);
        do_ret(); ser_rx = 1'b0; ser_tx = 1'b1; insn_done = 1'b1; steps(3);
        chk(got_n == 2 && got_vec[1] == 'h23, "R8 serial still pending", got_vec[1], 'h23);
        ser_tx = 1'b0; do_ret();

        // R10 no take on the return edge
        got_n = 0; irq_en = 8'h8A; tmr0 = 1'b1; insn_done = 1'b1; steps(3);
        insn_done = 1'b0; tmr1 = 1'b1; steps(2);
        chk(got_n == 1, "R10 low running blocks timer1", got_n, 1);
        insn_done = 1'b1; handler_ret = 1'b1; step();
        chk(got_n == 1, "R10 no take at return edge", got_n, 1);
        handler_ret = 1'b0; step();
        chk(got_n == 2 && got_vec[1] == 'h1B, "R10 take on next boundary", got_vec[1], 'h1B);
        do_ret(); steps(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule